// File: doc/BRIEF.md
# Byte-Lane Write Controller with Pipelined Array

This block sits at the front of a synchronous memory that stores words split into byte lanes. On each rising clock edge it samples an address, a word of write data and three active-low write controls. These are a global write, a byte-write enable and one byte-write select per lane. It decodes them into a per-lane write strobe or a read request and holds the result in a capture stage. On the following edge the stored word is updated lane by lane, or the addressed word is loaded into the output register.

The global write forces every lane to be written and ignores the other controls. A partial write needs the byte-write enable together with the selects of the wanted lanes. When neither the global write nor the byte-write enable is asserted, the cycle is a read. When the byte-write enable is asserted but no lane is selected, the cycle does nothing. Because the array is updated one edge after capture, a read issued in the very next cycle already sees the new data.

Top module: `byte_write_ctrl`

## Requirements
- R1: While reset is asserted at a clock edge, the output register valid flag, the registered lane strobes and the registered write data all clear to zero on that edge.
- R2: A cycle with the global write input low produces a registered lane strobe of all ones on the capture edge, whatever the byte-write enable and the lane selects are.
- R3: With the global write input high and the byte-write enable low, the registered strobe bit of lane i is 1 exactly when that lane's select is low. Lane i occupies data bits [i*LANE_W +: LANE_W].
- R4: With both the global write input and the byte-write enable high, the cycle is a read: the lane selects have no effect and the registered strobe is zero.
- R5: With the byte-write enable low and every lane select high, nothing is written. No read starts: on the edge after capture the valid flag is low and the output data keeps its previous value.
- R6: A read captured on edge N loads the addressed word into the output data on edge N+1 and raises the valid flag there. On an edge whose captured cycle is not a read, the valid flag is low.
- R7: A write captured on edge N updates the selected lanes of the array on edge N+1, leaving the unselected lanes unchanged. A read of the same address captured on edge N+1 returns the updated word.
- R8: The registered write data equals the data word sampled on the capture edge of a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for all registers |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Word address |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low, qualifies lane selects |
| bw_n | input | LANES | Per-lane byte-write selects, active low |
| wdata | input | LANES*LANE_W | Write data word |
| lane_stb | output | LANES | Registered per-lane write strobe |
| wdata_q | output | LANES*LANE_W | Registered copy of write data |
| rdata | output | LANES*LANE_W | Read data output register |
| rvalid | output | 1 | High when rdata was loaded by the most recent edge |

## Verification
The bench builds the block with four 8-bit lanes and a 4-bit address, so the array holds 16 words. With that depth, random addresses land on earlier-written words often enough that partial writes are merged onto real prior contents rather than onto fresh ones. Four lanes put all sixteen lane masks within reach of the random stimulus. The empty mask and the full mask also run as directed cases, as do global write with conflicting lane selects and a read issued directly behind a write to the same word.

// File: rtl/bwc_pkg.sv
// Shared types for the byte-lane write controller.
// Assumes nothing beyond a synthesizable SystemVerilog flow.
package bwc_pkg;

    // Operation carried by a captured cycle
    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } bwc_op_e;

endpackage

// File: rtl/bwc_decode.sv
// Combinational decode of the active-low write controls into a per-lane
// write enable and an operation type.
// Assumes: global write outranks everything; lane selects only count
// while the byte-write enable is low.
module bwc_decode
    import bwc_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_en,
    output bwc_op_e          op
);

    logic byte_path;

    // Byte path is open only when global write is idle and enable is low
    always_comb byte_path = gw_n && !bwe_n;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Per-lane enable: global write, or qualified lane select
        always_comb lane_en[g] = !gw_n || (byte_path && !bw_n[g]);
    end

    // Operation type: write if any lane enabled, read if no write control
    always_comb begin
        if (|lane_en)
            op = OP_WRITE;
        else if (gw_n && bwe_n)
            op = OP_READ;
        else
            op = OP_NONE;
    end

endmodule

// File: rtl/bwc_capture.sv
// Capture stage: registers address, lane strobes, write data and the read
// request on the rising edge.
// Assumes synchronous active-low reset; address is not cleared.
module bwc_capture
    import bwc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 6,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_en,
    input  bwc_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  stb_q,
    output logic [DATA_W-1:0] data_q,
    output logic              rd_q
);

    // Address register, no reset needed
    always_ff @(posedge clk) begin
        addr_q <= addr;
    end

    // Control and data registers with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q  <= '0;
            data_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            stb_q  <= lane_en;
            data_q <= (op == OP_WRITE) ? wdata : data_q;
            rd_q   <= (op == OP_READ);
        end
    end

    // R6
    rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|stb_q) |-> !rd_q);

endmodule

// File: rtl/bwc_lane_bank.sv
// One byte lane of the array with its own output register. Writes the lane
// when its strobe is set, loads the output register on a read.
// Assumes at most one of write strobe and read request is set per cycle.
module bwc_lane_bank #(
    parameter int LANE_W = 8,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              wr_stb,
    input  logic              rd_req,
    input  logic [LANE_W-1:0] wr_byte,
    output logic [LANE_W-1:0] rd_byte
);

    logic [LANE_W-1:0] mem [DEPTH];

    // Self-timed lane write on the edge after capture
    always_ff @(posedge clk) begin
        if (rst_n && wr_stb)
            mem[addr_q] <= wr_byte;
    end

    // Output register: clears on reset, loads only on a read
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_byte <= '0;
        else if (rd_req)
            rd_byte <= mem[addr_q];
    end

    // R5
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_byte));

endmodule

// File: rtl/byte_write_ctrl.sv
// Top of the byte-lane write controller: decode, capture stage and one
// array bank per lane, plus the read-valid flag.
// Assumes all write controls are active low; reset is synchronous.
module byte_write_ctrl
    import bwc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 6,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [LANES-1:0]  bw_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  lane_stb,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    logic [LANES-1:0]  lane_en;
    bwc_op_e           op;
    logic [ADDR_W-1:0] addr_q;
    logic              rd_q;

    bwc_decode #(.LANES(LANES)) u_dec (
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_en (lane_en),
        .op      (op)
    );

    bwc_capture #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .lane_en (lane_en),
        .op      (op),
        .wdata   (wdata),
        .addr_q  (addr_q),
        .stb_q   (lane_stb),
        .data_q  (wdata_q),
        .rd_q    (rd_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        bwc_lane_bank #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .addr_q  (addr_q),
            .wr_stb  (lane_stb[g]),
            .rd_req  (rd_q),
            .wr_byte (wdata_q[g*LANE_W +: LANE_W]),
            .rd_byte (rdata[g*LANE_W +: LANE_W])
        );
    end

    // Valid flag follows the read request one edge later
    always_ff @(posedge clk) begin
        if (!rst_n)
            rvalid <= 1'b0;
        else
            rvalid <= rd_q;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!rvalid && lane_stb == '0 && wdata_q == '0));

    // R2
    gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(gw_n)) |-> (&lane_stb));

    // R4
    read_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(gw_n) && $past(bwe_n)) |-> (lane_stb == '0));

    // R5
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && !bwe_n && (&bw_n)) |=> ##1 !rvalid);

endmodule

// File: tb/tb_byte_write_ctrl.sv
`timescale 1ns/1ps
module tb_byte_write_ctrl;

    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int ADDR_W = 4;
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              gw_n = 1'b1;
    logic              bwe_n = 1'b0;
    logic [LANES-1:0]  bw_n = '1;
    logic [DATA_W-1:0] wdata = '0;
    logic [LANES-1:0]  lane_stb;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata;
    logic              rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] ref_mem [DEPTH];

    always #4 clk = ~clk;

    byte_write_ctrl #(.LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n),
        .bw_n(bw_n), .wdata(wdata), .lane_stb(lane_stb), .wdata_q(wdata_q),
        .rdata(rdata), .rvalid(rvalid)
    );

    function automatic logic [LANES-1:0] exp_mask(logic g, logic b, logic [LANES-1:0] s);
        if (!g) return '1;
        if (!b) return ~s;
        return '0;
    endfunction

    function automatic logic [DATA_W-1:0] merge(logic [DATA_W-1:0] old_w,
            logic [DATA_W-1:0] new_w, logic [LANES-1:0] m);
        logic [DATA_W-1:0] r = old_w;
        for (int i = 0; i < LANES; i++)
            if (m[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        return r;
    endfunction

    task automatic chk(bit ok, string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive_nop();
        gw_n = 1'b1; bwe_n = 1'b0; bw_n = '1;
    endtask

    // Write; returns at negedge after the array-write edge
    task automatic do_write(logic [ADDR_W-1:0] a, logic g, logic b,
            logic [LANES-1:0] s, logic [DATA_W-1:0] d, string req);
        logic [LANES-1:0] m = exp_mask(g, b, s);
        addr = a; gw_n = g; bwe_n = b; bw_n = s; wdata = d;
        @(posedge clk); @(negedge clk);
        chk(lane_stb == m, req, DATA_W'(lane_stb), DATA_W'(m));
        if (m != '0) chk(wdata_q == d, "R8", wdata_q, d);
        drive_nop();
        @(posedge clk); @(negedge clk);
        ref_mem[a] = merge(ref_mem[a], d, m);
    endtask

    // Read with random lane selects; checks at negedge after load edge
    task automatic do_read(logic [ADDR_W-1:0] a, string req);
        addr = a; gw_n = 1'b1; bwe_n = 1'b1; bw_n = LANES'($urandom);
        @(posedge clk); @(negedge clk);
        chk(lane_stb == '0, "R4", DATA_W'(lane_stb), '0);
        drive_nop();
        @(posedge clk); @(negedge clk);
        chk(rvalid == 1'b1, "R6", DATA_W'(rvalid), 1);
        chk(rdata == ref_mem[a], req, rdata, ref_mem[a]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DATA_W-1:0] held;
        void'($urandom(32'h5EED1));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rvalid == 1'b0 && lane_stb == '0 && wdata_q == '0, "R1",
            {rvalid, lane_stb, wdata_q[DATA_W-LANES-2:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 initialise every word with global write, conflicting selects
        for (int a = 0; a < DEPTH; a++) begin
            ref_mem[a] = 'x;
            do_write(ADDR_W'(a), 1'b0, 1'(a), LANES'(a), DATA_W'($urandom), "R2");
        end
        for (int a = 0; a < DEPTH; a++) do_read(ADDR_W'(a), "R2");

        // R3 directed: single lane and full mask via byte path
        do_write(4'd3, 1'b1, 1'b0, 4'b1101, 32'hA1B2C3D4, "R3");
        do_read(4'd3, "R3");
        do_write(4'd3, 1'b1, 1'b0, 4'b0000, 32'h0F1E2D3C, "R3");
        do_read(4'd3, "R3");

        // R5 empty mask: no write, no read, output held
        do_read(4'd5, "R6");
        held = rdata;
        do_write(4'd5, 1'b1, 1'b0, 4'b1111, 32'hDEADBEEF, "R5");
        chk(rvalid == 1'b0, "R5", DATA_W'(rvalid), 0);
        chk(rdata == held, "R5", rdata, held);
        do_read(4'd5, "R5");

        // R7 read right behind a write to the same word
        addr = 4'd9; gw_n = 1'b1; bwe_n = 1'b0; bw_n = 4'b1010; wdata = 32'h11223344;
        @(posedge clk); @(negedge clk);
        ref_mem[9] = merge(ref_mem[9], 32'h11223344, 4'b0101);
        gw_n = 1'b1; bwe_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk(rvalid == 1'b0, "R6", DATA_W'(rvalid), 0);
        drive_nop();
        @(posedge clk); @(negedge clk);
        chk(rvalid == 1'b1 && rdata == ref_mem[9], "R7", rdata, ref_mem[9]);

        // Random mix of writes and reads
        for (int i = 0; i < 300; i++) begin
            logic [ADDR_W-1:0] a = ADDR_W'($urandom);
            int k = $urandom_range(0, 9);
            if (k < 2)
                do_write(a, 1'b0, 1'($urandom), LANES'($urandom), DATA_W'($urandom), "R2");
            else if (k < 6)
                do_write(a, 1'b1, 1'b0, LANES'($urandom), DATA_W'($urandom), "R3");
            else
                do_read(a, "R7");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule